// File: doc/BRIEF.md
# SD Card Clock Divider Control

This block produces the SD card clock from a fixed base clock (150 MHz in the target system; here the block's own input clock) through a programmable divider. Software drives it through one 16-bit control word. The word holds an 8-bit ratio select field, an internal clock enable, a read-only settled flag and a card clock enable. The select encoding is not a plain binary divisor. Codes 0 to 3 give the linear ratios 1, 2, 4 and 3, in that order. A one-hot code N from 4 to 128 gives ratio 2N, so the ratios reach 256.

The expected sequence has three writes. Software first writes zero, which stops everything. It then writes the select code together with the internal enable, and polls the settled flag. When the flag is seen, it repeats the same word with the card enable added. The card enable is ignored until the divider has settled. The card clock is opened and closed only while the divided clock is low, so the first and the last pulse on the card pin are always full width.

Top module: `sd_clkdiv_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000 and the card clock output is low.
- R2: Field layout: the select code is in bits 15:8, the internal enable is bit 0, the settled flag is bit 1 and the card enable is bit 2. The settled flag is read-only, so writing 1 to it has no effect. Every other bit reads as zero.
- R3: Select code 0 gives ratio 1, code 1 gives ratio 2, code 3 gives ratio 3 and code 2 gives ratio 4. A code N equal to 4, 8, 16, 32, 64 or 128 gives ratio 2N.
- R4: For a ratio r of 2 or more, each output period is high for floor(r/2) base cycles and low for the remaining cycles. Ratio 1 passes the base clock through unchanged.
- R5: The settled flag reads 1 exactly 16 base-clock edges after the write that sets the internal enable with a defined code. It then stays at 1 while the word is left unchanged, and it never reads 1 while the internal enable is 0.
- R6: The card enable has no effect on the output until the settled flag is 1, even when it is written together with the internal enable.
- R7: With an undefined select code (for example 5), the output stays low and the settled flag never reads 1.
- R8: Writing 0x0000 stops the divider, clears the settled flag and holds the output low.
- R9: The settled flag reads 0 immediately after a write that clears the internal enable or changes the select code.
- R10: The card clock gate changes state only while the divided clock is low. A pulse in progress when the card enable is cleared runs to its full width, and no later pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; all divide ratios are relative to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; loads wr_data into the control word at the rising edge |
| wr_data | input | 16 | Control word value to write |
| rd_data | output | 16 | Current control word, including the live settled flag |
| sd_clk_out | output | 1 | Gated, divided card clock |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit select field at bit 8, and a 16-cycle settling delay. With these values every legal ratio can be measured, from the pass-through ratio 1 up to 256, within a few hundred cycles each. The settling delay is short enough that the bench can count each edge up to the flag rising. The ratios 3 and 4 show whether the swapped codes 2 and 3 are decoded correctly, and the odd ratio 3 shows the shortened high phase.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
   // Bit positions of the single-bit controls in the control word
   localparam int unsigned IEN_BIT = 0;
   localparam int unsigned STB_BIT = 1;
   localparam int unsigned CEN_BIT = 2;
   localparam int unsigned LOW_FIELD_TOP = 2;

   typedef struct packed {
      logic card_en;
      logic int_en;
   } sdclk_ctrl_t;
endpackage

// File: rtl/sdclk_sel_decode.sv
module sdclk_sel_decode #(
   parameter int unsigned SEL_W   = 8,
   parameter int unsigned RATIO_W = SEL_W + 1
) (
   input  logic [SEL_W-1:0]   sel_i,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               valid_o
);
   always_comb begin
      ratio_o = '0;
      valid_o = 1'b0;
      if (sel_i == SEL_W'(0)) begin
         ratio_o = RATIO_W'(1);
         valid_o = 1'b1;
      end else if (sel_i == SEL_W'(1)) begin
         ratio_o = RATIO_W'(2);
         valid_o = 1'b1;
      end else if (sel_i == SEL_W'(3)) begin
         ratio_o = RATIO_W'(3);
         valid_o = 1'b1;
      end else if (sel_i == SEL_W'(2)) begin
         ratio_o = RATIO_W'(4);
         valid_o = 1'b1;
      end else begin
         for (int k = 2; k < int'(SEL_W); k++) begin
            if (sel_i == SEL_W'(1 << k)) begin
               ratio_o = RATIO_W'(2 << k);
               valid_o = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
   parameter int unsigned RATIO_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               restart_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               raw_o,
   output logic               next_low_o
);
   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] cnt_inc;
   logic [RATIO_W-1:0] cnt_nxt;
   logic [RATIO_W-1:0] half;
   logic               raw_nxt;
   logic               hold;

   assign hold    = !run_i || restart_i;
   assign cnt_inc = cnt_q + 1'b1;
   assign cnt_nxt = (cnt_inc >= ratio_i) ? '0 : cnt_inc;
   assign half    = ratio_i >> 1;
   assign raw_nxt = cnt_nxt < half;
   // Value the divided clock will hold after the coming edge
   assign next_low_o = hold || !raw_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         raw_o <= 1'b0;
      end else if (hold) begin
         cnt_q <= '0;
         raw_o <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         raw_o <= raw_nxt;
      end
   end
endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle #(
   parameter int unsigned SETTLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic stable_o
);
   localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (!run_i || restart_i) cnt_q <= '0;
      else if (cnt_q != LAST)       cnt_q <= cnt_q + 1'b1;
   end

   assign stable_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic want_i,
   input  logic bypass_i,
   input  logic raw_i,
   input  logic next_low_i,
   output logic gate_o,
   output logic clk_o
);
   logic gate_n_q;

   // Divided path: the gate moves only at an edge after which the clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gate_o <= 1'b0;
      else if (next_low_i) gate_o <= want_i;
   end

   // Pass-through path: the gate moves on the falling edge, while clk is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_n_q <= 1'b0;
      else        gate_n_q <= want_i && bypass_i;
   end

   assign clk_o = bypass_i ? (clk && gate_n_q) : (raw_i && gate_o);
endmodule

// File: rtl/sd_clkdiv_ctrl.sv
module sd_clkdiv_ctrl #(
   parameter int unsigned REG_W         = 16,
   parameter int unsigned SEL_W         = 8,
   parameter int unsigned SEL_LSB       = 8,
   parameter int unsigned SETTLE_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             sd_clk_out
);
   import sdclk_pkg::*;

   localparam int unsigned RATIO_W = SEL_W + 1;

   generate
      if (SEL_LSB + SEL_W > REG_W || SEL_LSB <= LOW_FIELD_TOP) begin : g_bad_layout
         $error("select field overlaps control bits or exceeds the word");
      end
      if (SEL_W < 2) begin : g_bad_sel
         $error("select field must be at least 2 bits");
      end
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("settling delay must be at least one cycle");
      end
   endgenerate

   logic [SEL_W-1:0]   sel_q;
   sdclk_ctrl_t        ctrl_q;
   logic [SEL_W-1:0]   wr_sel;
   logic               restart;
   logic               run;
   logic [RATIO_W-1:0] ratio;
   logic               code_valid;
   logic               stable;
   logic               raw_clk;
   logic               next_low;
   logic               gate_q;
   logic               bypass;
   logic               unused_wr;

   assign wr_sel    = wr_data[SEL_LSB +: SEL_W];
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         ctrl_q <= '0;
      end else if (wr_en) begin
         sel_q          <= wr_sel;
         ctrl_q.int_en  <= wr_data[IEN_BIT];
         ctrl_q.card_en <= wr_data[CEN_BIT];
      end
   end

   assign restart = wr_en && (wr_sel != sel_q);
   assign run     = ctrl_q.int_en && code_valid;
   assign bypass  = (ratio == RATIO_W'(1));

   sdclk_sel_decode #(.SEL_W(SEL_W), .RATIO_W(RATIO_W)) u_dec (
      .sel_i   (sel_q),
      .ratio_o (ratio),
      .valid_o (code_valid)
   );

   sdclk_divider #(.RATIO_W(RATIO_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .restart_i  (restart),
      .ratio_i    (ratio),
      .raw_o      (raw_clk),
      .next_low_o (next_low)
   );

   sdclk_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .restart_i (restart),
      .stable_o  (stable)
   );

   sdclk_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .want_i     (ctrl_q.card_en && stable),
      .bypass_i   (bypass),
      .raw_i      (raw_clk),
      .next_low_i (next_low),
      .gate_o     (gate_q),
      .clk_o      (sd_clk_out)
   );

   always_comb begin
      rd_data                    = '0;
      rd_data[SEL_LSB +: SEL_W]  = sel_q;
      rd_data[IEN_BIT]           = ctrl_q.int_en;
      rd_data[STB_BIT]           = stable;
      rd_data[CEN_BIT]           = ctrl_q.card_en;
   end
endmodule

// File: rtl/sdclk_div_chk.sv
module sdclk_div_chk #(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned SEL_W   = 8,
   parameter int unsigned SEL_LSB = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [SEL_W-1:0] sel_q,
   input logic             int_en,
   input logic             stable,
   input logic             code_valid,
   input logic             gate_q,
   input logic             raw_clk
);
   AST_STABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      stable |-> int_en); // R5

   AST_STABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stable && !wr_en) |=> stable); // R5

   AST_SEL_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[SEL_LSB +: SEL_W] != sel_q) |=> !stable); // R9

   AST_EN_CLEAR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[0]) |=> !stable); // R9

   AST_INVALID_NO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !code_valid |-> !stable); // R7

   AST_GATE_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q) |-> $past(stable)); // R6

   AST_GATE_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_q) |-> !raw_clk); // R10
endmodule

bind sd_clkdiv_ctrl sdclk_div_chk #(
   .REG_W   (REG_W),
   .SEL_W   (SEL_W),
   .SEL_LSB (SEL_LSB)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .sel_q      (sel_q),
   .int_en     (ctrl_q.int_en),
   .stable     (stable),
   .code_valid (code_valid),
   .gate_q     (gate_q),
   .raw_clk    (raw_clk)
);

// File: tb/tb_sd_clkdiv_ctrl.sv
`timescale 1ns/1ps
module tb_sd_clkdiv_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        sd_clk_out;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   sd_clkdiv_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .sd_clk_out(sd_clk_out)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_settled();
      for (int i = 0; i < 16; i++) tick();
   endtask

   // Waits for a rising edge of the card clock, then measures high and low run
   task automatic measure(int r, string req);
      logic prev;
      int   hi = 0;
      int   lo = 0;
      bit   found = 0;
      prev = sd_clk_out;
      for (int i = 0; i < 2000 && !found; i++) begin
         tick();
         if (!prev && sd_clk_out) found = 1;
         prev = sd_clk_out;
      end
      if (found) begin
         hi = 1;
         for (int i = 0; i < 600 && sd_clk_out; i++) begin
            tick();
            if (sd_clk_out) hi++;
         end
         lo = 1;
         for (int i = 0; i < 600; i++) begin
            tick();
            if (sd_clk_out) break;
            lo++;
         end
      end
      check({req, " high phase"}, hi, r / 2);
      check({req, " low phase"}, lo, r - r / 2);
   endtask

   task automatic t_reset();
      check("R1 reset word", int'(rd_data), 0);
      check("R1 reset output", int'(sd_clk_out), 0);
   endtask

   task automatic t_layout();
      wr(16'h1002);                     // only the settled bit written
      check("R2 settled bit read-only", int'(rd_data), 16'h1000);
      wr(16'hA5FD);                     // code A5, int_en, card_en, stray bits
      check("R2 field layout", int'(rd_data), 16'hA505);
      wr(16'h0000);
   endtask

   task automatic t_settle_and_card();
      int highs = 0;
      wr(16'h0205);                     // ratio 4, int_en and card_en together
      for (int i = 0; i < 15; i++) begin
         tick();
         if (sd_clk_out) highs++;
         if (rd_data[1]) highs += 100;
      end
      check("R5 flag low before 16 edges", highs >= 100 ? 1 : 0, 0);
      check("R6 card clock held before settled", highs % 100, 0);
      tick();
      check("R5 flag at 16th edge", int'(rd_data[1]), 1);
      measure(4, "R6 card clock after settled");
      wr(16'h0405);                     // change code while running
      check("R9 flag cleared by code change", int'(rd_data[1]), 0);
      wait_settled();
      wr(16'h0404);                     // clear int_en
      check("R9 flag cleared by enable clear", int'(rd_data[1]), 0);
      wr(16'h0000);
   endtask

   task automatic t_ratio(logic [7:0] code, int r);
      wr(16'h0000);
      wr({code, 8'h01});
      wait_settled();
      check($sformatf("R5 settled for code %0d", code), int'(rd_data[1]), 1);
      wr({code, 8'h05});
      measure(r, $sformatf("R3 R4 code %0d ratio %0d", code, r));
   endtask

   task automatic t_bypass();
      int bad = 0;
      wr(16'h0000);
      wr(16'h0001);
      wait_settled();
      wr(16'h0005);
      tick();
      tick();
      for (int i = 0; i < 10; i++) begin
         @(posedge clk);
         #1;
         if (sd_clk_out !== 1'b1) bad++;
         #2.5;
         if (sd_clk_out !== 1'b0) bad++;
      end
      check("R3 R4 ratio 1 follows base clock", bad, 0);
   endtask

   task automatic t_invalid();
      int st = 0;
      int hi = 0;
      wr(16'h0000);
      wr(16'h0505);
      for (int i = 0; i < 40; i++) begin
         tick();
         if (rd_data[1]) st++;
         if (sd_clk_out) hi++;
      end
      check("R7 no flag for undefined code", st, 0);
      check("R7 output low for undefined code", hi, 0);
   endtask

   task automatic t_stop();
      int hi = 0;
      wr(16'h0000);
      wr(16'h0805);
      wait_settled();
      measure(16, "R8 running before stop");
      wr(16'h0000);
      check("R8 word cleared", int'(rd_data), 0);
      for (int i = 0; i < 40; i++) begin
         tick();
         if (sd_clk_out) hi++;
      end
      check("R8 output held low", hi, 0);
   endtask

   task automatic t_gate_off();
      logic prev;
      int   highs = 0;
      bit   found = 0;
      wr(16'h0000);
      wr(16'h0401);
      wait_settled();
      wr(16'h0405);
      prev = sd_clk_out;
      for (int i = 0; i < 100 && !found; i++) begin
         tick();
         if (!prev && sd_clk_out) found = 1;
         prev = sd_clk_out;
      end
      highs = found ? 1 : 0;
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 16'h0401;               // drop card_en mid-pulse
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      if (sd_clk_out) highs++;
      for (int i = 0; i < 30; i++) begin
         tick();
         if (sd_clk_out) highs++;
      end
      check("R10 last pulse full width, none after", highs, 4);
      wr(16'h0000);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_layout();
      t_settle_and_card();
      t_bypass();
      t_ratio(8'd1, 2);
      t_ratio(8'd3, 3);
      t_ratio(8'd2, 4);
      t_ratio(8'd4, 8);
      t_ratio(8'd8, 16);
      t_ratio(8'd16, 32);
      t_ratio(8'd32, 64);
      t_ratio(8'd64, 128);
      t_ratio(8'd128, 256);
      t_invalid();
      t_stop();
      t_gate_off();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule